// File: doc/BRIEF.md
# Background and Window Tile Fetch Addresser

This block produces, for one scanline at a time, the video-memory addresses a tile renderer needs for the two tile layers: a background plane that scrolls and wraps inside a 256 by 256 pixel map, and a window plane that does not wrap and that covers the background from a programmable column onward. A line request carries the line number and is accepted on a valid/ready handshake. The scroll, window position, map-select and index-mode inputs are captured in the same cycle.

After a request is accepted, the block emits one record per visible pixel, 160 in total, on a valid/ready stream. Each record holds the tilemap entry address, the tile index resolved from the map byte, the fine X and Y inside the tile, a window flag, and the address of the two-byte tile row in tile data. The map byte comes back on `map_data` in the same cycle as the address on `px_map_addr`, so the memory model answers combinationally. Back-pressure is lossless. While `px_ready` is low, the current record and the address it presents stay unchanged, and the walk continues only when a record is taken. A new line request is refused until the last pixel of the current line has been taken.

Top module: `tile_fetch_addresser`

## Requirements
- R1: While reset is asserted and directly after it, `px_valid` is 0 and `line_ready` is 1.
- R2: A request taken with `line_valid` and `line_ready` both high yields exactly 160 records with `px_x` running 0 to 159. `px_last` is high only on 159. `line_ready` stays low until record 159 has been taken.
- R3: While `px_valid` is 1 and `px_ready` is 0, the record fields hold their values and `px_valid` stays 1.
- R4: A background pixel uses row = (line + scroll Y) mod 256 and fine Y = row mod 8. Its map address is base + (row div 8) * 32 + column, with base 0x1800 when its map select is 0 and 0x1C00 when it is 1.
- R5: For a background pixel at screen X = x, the column is ((scroll X + x) div 8) mod 32 and fine X is (scroll X + x) mod 8. At x = 0 this gives column scroll X div 8 and fine X scroll X mod 8.
- R6: A line carries window pixels only if window X ≤ 166, window Y ≤ 143 and line ≥ window Y. Otherwise `px_win` is 0 on every pixel of the line.
- R7: On a window line the window starts at e = window X − 7, or at 0 when window X < 7. `px_win` is 1 exactly for x ≥ e.
- R8: A window pixel uses row = line − window Y and fine Y = row mod 8. Its fine X starts at e mod 8 and steps by one each pixel. Its column starts at 0 and increases each time fine X wraps from 7 to 0, so column = x div 8 − e div 8 and fine X = x mod 8. The map address is the window base + (row div 8) * 32 + column, with the same base encoding as R4.
- R9: With the signed index mode at 1, a map byte below 128 gives tile index byte + 256. With the mode at 0, or for bytes of 128 and above, the tile index is the byte itself (9-bit `px_tile`).
- R10: `px_data_addr` = tile index * 16 + fine Y * 2.
- R11: Scroll, window, map-select and mode inputs that change after a request is accepted have no effect on the records of that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_valid | input | 1 | Line request valid |
| line_ready | output | 1 | Block idle, request can be taken |
| line_num | input | 8 | Line number of the request |
| scroll_x | input | 8 | Background horizontal scroll |
| scroll_y | input | 8 | Background vertical scroll |
| win_x | input | 8 | Window X position (start column + 7) |
| win_y | input | 8 | Window first line |
| bg_map_sel | input | 1 | Background map base select |
| win_map_sel | input | 1 | Window map base select |
| signed_idx | input | 1 | Signed tile index mode |
| px_map_addr | output | 13 | Tilemap entry address of the current record |
| map_data | input | 8 | Map byte at `px_map_addr` (same cycle) |
| px_valid | output | 1 | Record valid |
| px_ready | input | 1 | Record taken |
| px_x | output | 8 | Screen X of the record |
| px_win | output | 1 | Record comes from the window layer |
| px_tile | output | 9 | Resolved tile index |
| px_fine_x | output | 3 | Fine X in the tile |
| px_fine_y | output | 3 | Fine Y in the tile |
| px_data_addr | output | 13 | Tile row address in tile data |
| px_last | output | 1 | Last record of the line |

## Verification
The hardest state to reach is the window walker holding its column across a stalled record exactly at the window start or at a fine-X wrap. The window column only advances on records that are both taken and inside the window. The bench sweeps every window X from 0 to 170 on an active line. It drops `px_ready` on a pseudo-random quarter of the records and checks at each stall that the record holds, so stalls land on the first window pixel and on wrap points for many start offsets. Separate lines change every configuration input just after acceptance, to show that the captured configuration governs the whole line.

// File: rtl/tfa_pkg.sv
package tfa_pkg;
  localparam int COORD_W = 8;
  typedef logic [COORD_W-1:0] coord_t;

  typedef struct packed {
    coord_t line;
    coord_t scx;
    coord_t scy;
    coord_t wx;
    coord_t wy;
    logic   bg_sel;
    logic   win_sel;
    logic   signed_mode;
  } line_cfg_t;
endpackage

// File: rtl/tfa_line_ctl.sv
module tfa_line_ctl
  import tfa_pkg::*;
#(
  parameter int SCREEN_W = 160,
  localparam int X_W = $clog2(SCREEN_W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           line_valid,
  output logic           line_ready,
  input  line_cfg_t      cfg_in,
  output line_cfg_t      cfg_q,
  output logic           load,
  input  logic           px_ready,
  output logic           px_valid,
  output logic [X_W-1:0] x,
  output logic           last,
  output logic           fire
);
  logic busy;

  assign px_valid   = busy;
  assign line_ready = !busy;
  assign load       = line_valid && !busy;
  assign fire       = busy && px_ready;
  assign last       = (x == X_W'(SCREEN_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      x     <= '0;
      cfg_q <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      x     <= '0;
      cfg_q <= cfg_in;
    end else if (fire) begin
      if (last) busy <= 1'b0;
      else      x    <= x + 1'b1;
    end
  end

  // R2: a taken request starts the walk at screen X 0
  a_r2_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy && x == '0));
  // R2: a taken record moves X on by exactly one
  a_r2_x_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !last) |=> (x == $past(x) + 1'b1));
  // R2: the line ends once the last record is taken
  a_r2_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last) |=> !busy);
  // R11: captured configuration does not move during a line
  a_r11_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(fire && last)) |=> $stable(cfg_q));
endmodule

// File: rtl/tfa_layer_walk.sv
module tfa_layer_walk #(
  parameter int TILE_W   = 8,
  parameter int MAP_COLS = 32,
  parameter bit WRAP     = 1'b1,
  localparam int FINE_W  = $clog2(TILE_W),
  localparam int COL_W   = $clog2(MAP_COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [COL_W-1:0]  init_col,
  input  logic [FINE_W-1:0] init_fine,
  input  logic              step,
  output logic [COL_W:0]    col,
  output logic [FINE_W-1:0] fine
);
  localparam logic [FINE_W-1:0] FINE_MAX = FINE_W'(TILE_W - 1);

  logic [COL_W:0] col_inc;

  generate
    if (WRAP) begin : g_wrap
      assign col_inc = {1'b0, col[COL_W-1:0] + 1'b1};

      // R5: the background column wraps from the last map column to 0
      a_r5_col_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && fine == FINE_MAX && col[COL_W-1:0] == {COL_W{1'b1}})
          |=> (col == '0));
    end else begin : g_flat
      assign col_inc = col + 1'b1;

      // R8: the window column never leaves the map width
      a_r8_col_in_map: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (col < (COL_W+1)'(MAP_COLS)));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col  <= '0;
      fine <= '0;
    end else if (load) begin
      col  <= {1'b0, init_col};
      fine <= init_fine;
    end else if (step) begin
      fine <= fine + 1'b1;
      if (fine == FINE_MAX) col <= col_inc;
    end
  end
endmodule

// File: rtl/tfa_tile_resolve.sv
module tfa_tile_resolve #(
  parameter int ADDR_W     = 13,
  parameter int TILE_BYTES = 16,
  parameter int ROW_BYTES  = 2,
  parameter int FINE_W     = 3,
  localparam int TB_SH     = $clog2(TILE_BYTES),
  localparam int RB_SH     = $clog2(ROW_BYTES)
) (
  input  logic [7:0]        raw,
  input  logic              signed_mode,
  input  logic [FINE_W-1:0] fine_y,
  output logic [8:0]        tile,
  output logic [ADDR_W-1:0] data_addr
);
  always_comb begin
    tile      = (signed_mode && !raw[7]) ? {1'b1, raw} : {1'b0, raw};
    data_addr = ADDR_W'({tile, {TB_SH{1'b0}}}) + ADDR_W'({fine_y, {RB_SH{1'b0}}});
  end
endmodule

// File: rtl/tile_fetch_addresser.sv
module tile_fetch_addresser
  import tfa_pkg::*;
#(
  parameter int SCREEN_W   = 160,
  parameter int TILE_W     = 8,
  parameter int MAP_COLS   = 32,
  parameter int ADDR_W     = 13,
  parameter int MAP0_BASE  = 'h1800,
  parameter int MAP1_BASE  = 'h1C00,
  parameter int WIN_X_OFS  = 7,
  parameter int WIN_X_LAST = 166,
  parameter int WIN_Y_LAST = 143
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_valid,
  output logic              line_ready,
  input  logic [7:0]        line_num,
  input  logic [7:0]        scroll_x,
  input  logic [7:0]        scroll_y,
  input  logic [7:0]        win_x,
  input  logic [7:0]        win_y,
  input  logic              bg_map_sel,
  input  logic              win_map_sel,
  input  logic              signed_idx,
  output logic [12:0]       px_map_addr,
  input  logic [7:0]        map_data,
  output logic              px_valid,
  input  logic              px_ready,
  output logic [7:0]        px_x,
  output logic              px_win,
  output logic [8:0]        px_tile,
  output logic [2:0]        px_fine_x,
  output logic [2:0]        px_fine_y,
  output logic [12:0]       px_data_addr,
  output logic              px_last
);
  localparam int FINE_W = $clog2(TILE_W);
  localparam int COL_W  = $clog2(MAP_COLS);
  localparam int X_W    = $clog2(SCREEN_W);

  function automatic coord_t win_start(coord_t wx);
    return (wx >= coord_t'(WIN_X_OFS)) ? wx - coord_t'(WIN_X_OFS) : '0;
  endfunction

  function automatic logic [ADDR_W-1:0] map_base(logic sel);
    return sel ? ADDR_W'(MAP1_BASE) : ADDR_W'(MAP0_BASE);
  endfunction

  line_cfg_t         cfg_in, cfg_q;
  logic              load, fire, busy, last;
  logic [X_W-1:0]    x;
  logic [COL_W:0]    bg_col, win_col;
  logic [FINE_W-1:0] bg_fine, win_fine;
  coord_t            bg_row, win_row, sel_row, start_q, start_in;
  logic              win_line, pix_win;
  logic [COL_W:0]    sel_col;
  logic [ADDR_W-1:0] sel_base;

  assign cfg_in = '{line: line_num, scx: scroll_x, scy: scroll_y, wx: win_x, wy: win_y,
                    bg_sel: bg_map_sel, win_sel: win_map_sel, signed_mode: signed_idx};

  tfa_line_ctl #(.SCREEN_W(SCREEN_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .line_ready(line_ready),
    .cfg_in(cfg_in), .cfg_q(cfg_q), .load(load), .px_ready(px_ready),
    .px_valid(busy), .x(x), .last(last), .fire(fire)
  );

  assign start_in = win_start(cfg_in.wx);
  assign start_q  = win_start(cfg_q.wx);
  assign win_line = (cfg_q.wx <= coord_t'(WIN_X_LAST)) &&
                    (cfg_q.wy <= coord_t'(WIN_Y_LAST)) &&
                    (cfg_q.line >= cfg_q.wy);
  assign pix_win  = busy && win_line && (COORD_W'(x) >= start_q);

  tfa_layer_walk #(.TILE_W(TILE_W), .MAP_COLS(MAP_COLS), .WRAP(1'b1)) u_bg_walk (
    .clk(clk), .rst_n(rst_n), .load(load),
    .init_col(cfg_in.scx[FINE_W +: COL_W]), .init_fine(cfg_in.scx[FINE_W-1:0]),
    .step(fire), .col(bg_col), .fine(bg_fine)
  );

  tfa_layer_walk #(.TILE_W(TILE_W), .MAP_COLS(MAP_COLS), .WRAP(1'b0)) u_win_walk (
    .clk(clk), .rst_n(rst_n), .load(load),
    .init_col('0), .init_fine(start_in[FINE_W-1:0]),
    .step(fire && pix_win), .col(win_col), .fine(win_fine)
  );

  assign bg_row  = cfg_q.line + cfg_q.scy;
  assign win_row = cfg_q.line - cfg_q.wy;
  assign sel_row  = pix_win ? win_row : bg_row;
  assign sel_col  = pix_win ? win_col : bg_col;
  assign sel_base = pix_win ? map_base(cfg_q.win_sel) : map_base(cfg_q.bg_sel);

  assign px_map_addr = sel_base
                     + ADDR_W'({sel_row[COORD_W-1:FINE_W], {COL_W{1'b0}}})
                     + ADDR_W'(sel_col);
  assign px_fine_x = pix_win ? win_fine : bg_fine;
  assign px_fine_y = sel_row[FINE_W-1:0];
  assign px_valid  = busy;
  assign px_x      = 8'(x);
  assign px_win    = pix_win;
  assign px_last   = busy && last;

  tfa_tile_resolve #(.ADDR_W(ADDR_W), .FINE_W(FINE_W)) u_resolve (
    .raw(map_data), .signed_mode(cfg_q.signed_mode), .fine_y(px_fine_y),
    .tile(px_tile), .data_addr(px_data_addr)
  );

  // R3: a stalled record holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && !px_ready) |=> (px_valid && $stable(px_map_addr) && $stable(px_x) &&
                                 $stable(px_win) && $stable(px_fine_x)));
  // R7: once the window starts on a line it covers the rest of it
  a_r7_win_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && px_ready && px_win && !px_last) |=> px_win);
  // R6: no window pixel when the window Y is off screen
  a_r6_win_off: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && cfg_q.wy > coord_t'(WIN_Y_LAST)) |-> !px_win);
  // R9: signed mode only yields indices 128..383
  a_r9_signed_range: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && cfg_q.signed_mode) |-> (px_tile >= 9'd128 && px_tile <= 9'd383));
  // R5: background fine X steps by one per taken record
  a_r5_fine_step: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && px_ready && !px_win && !px_last)
      |=> (px_win || px_fine_x == $past(px_fine_x) + 1'b1));
endmodule

// File: tb/test_tile_fetch_addresser.sv
`timescale 1ns/1ps
module test_tile_fetch_addresser;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_valid = 1'b0;
  logic        line_ready;
  logic [7:0]  line_num = '0, scroll_x = '0, scroll_y = '0, win_x = '0, win_y = '0;
  logic        bg_map_sel = 1'b0, win_map_sel = 1'b0, signed_idx = 1'b0;
  logic [12:0] px_map_addr;
  logic [7:0]  map_data;
  logic        px_valid;
  logic        px_ready = 1'b0;
  logic [7:0]  px_x;
  logic        px_win;
  logic [8:0]  px_tile;
  logic [2:0]  px_fine_x, px_fine_y;
  logic [12:0] px_data_addr;
  logic        px_last;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_f(logic [12:0] a);
    logic [12:0] t;
    t = (a * 13'd37) ^ (a >> 5);
    return t[7:0];
  endfunction

  assign map_data = mem_f(px_map_addr);

  tile_fetch_addresser i_tile_fetch_addresser (
    .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .line_ready(line_ready),
    .line_num(line_num), .scroll_x(scroll_x), .scroll_y(scroll_y), .win_x(win_x),
    .win_y(win_y), .bg_map_sel(bg_map_sel), .win_map_sel(win_map_sel),
    .signed_idx(signed_idx), .px_map_addr(px_map_addr), .map_data(map_data),
    .px_valid(px_valid), .px_ready(px_ready), .px_x(px_x), .px_win(px_win),
    .px_tile(px_tile), .px_fine_x(px_fine_x), .px_fine_y(px_fine_y),
    .px_data_addr(px_data_addr), .px_last(px_last)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic run_line(int ln, int sx, int sy, int wx, int wy,
                          bit bsel, bit wsel, bit sgn, bit perturb);
    line_num = 8'(ln); scroll_x = 8'(sx); scroll_y = 8'(sy);
    win_x = 8'(wx); win_y = 8'(wy);
    bg_map_sel = bsel; win_map_sel = wsel; signed_idx = sgn;
    line_valid = 1'b1;
    chk("R2 line_ready idle", 32'(line_ready), 32'd1);
    @(posedge clk); @(negedge clk);
    line_valid = 1'b0;
    chk("R2 line_ready busy", 32'(line_ready), 32'd0);
    if (perturb) begin
      // R11: scramble every config input after acceptance
      scroll_x = ~scroll_x; scroll_y = scroll_y + 8'd77; win_x = win_x ^ 8'h5A;
      win_y = 8'd3; bg_map_sel = ~bg_map_sel; win_map_sel = ~win_map_sel;
      signed_idx = ~signed_idx; line_num = line_num + 8'd9;
    end
    for (int x = 0; x < 160; x++) begin
      int e, row, fy, fx, col, base, maddr, idx, daddr;
      bit act, w;
      string ta;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[1:0] == 2'b00) begin
        logic [31:0] snap;
        px_ready = 1'b0;
        snap = {px_map_addr, px_x, px_win, px_fine_x, px_valid};
        @(posedge clk); @(negedge clk);
        chk("R3 stalled record held",
            {px_map_addr, px_x, px_win, px_fine_x, px_valid}, snap);
      end
      px_ready = 1'b1;
      e   = (wx >= 7) ? wx - 7 : 0;
      act = (wx <= 166) && (wy <= 143) && (ln >= wy);
      w   = act && (x >= e);
      if (w) begin
        row = ln - wy; fx = x % 8; col = x / 8 - e / 8;
        base = wsel ? 'h1C00 : 'h1800;
      end else begin
        row = (ln + sy) % 256; fx = (sx + x) % 8; col = ((sx + x) / 8) % 32;
        base = bsel ? 'h1C00 : 'h1800;
      end
      fy    = row % 8;
      maddr = base + (row / 8) * 32 + col;
      idx   = mem_f(13'(maddr));
      if (sgn && idx < 128) idx += 256;
      daddr = idx * 16 + fy * 2;
      ta = perturb ? "R11 map address" : (w ? "R8 window map address" : "R4 bg map address");
      chk("R2 px_valid", 32'(px_valid), 32'd1);
      chk("R2 px_x", 32'(px_x), 32'(x));
      chk("R2 px_last", 32'(px_last), 32'(x == 159));
      chk(act ? "R7 window flag" : "R6 window flag", 32'(px_win), 32'(w));
      chk(ta, 32'(px_map_addr), 32'(maddr));
      chk(w ? "R8 fine x" : "R5 fine x", 32'(px_fine_x), 32'(fx));
      chk(w ? "R8 fine y" : "R4 fine y", 32'(px_fine_y), 32'(fy));
      chk("R9 tile index", 32'(px_tile), 32'(idx));
      chk("R10 data address", 32'(px_data_addr), 32'(daddr));
      @(posedge clk); @(negedge clk);
    end
    px_ready = 1'b0;
    chk("R2 idle after line", 32'(px_valid), 32'd0);
    chk("R2 ready after line", 32'(line_ready), 32'd1);
  endtask

  initial begin
    int wys[9];
    wys = '{0, 1, 7, 8, 100, 142, 143, 144, 200};
    repeat (3) @(negedge clk);
    chk("R1 px_valid in reset", 32'(px_valid), 32'd0);
    chk("R1 line_ready in reset", 32'(line_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 px_valid after reset", 32'(px_valid), 32'd0);
    chk("R1 line_ready after reset", 32'(line_ready), 32'd1);

    // R4 R5 R9: every scroll X, wrapping rows, both map bases and modes
    for (int sx = 0; sx < 256; sx++)
      run_line(sx % 144, sx, (sx * 3) % 256, 20, 200, sx[1], 1'b0, sx[0], 1'b0);

    // R7 R8: every window X start including off-screen values
    for (int wx = 0; wx <= 170; wx++)
      run_line(40, (wx * 5) % 256, wx, wx, 10, wx[2], wx[0], wx[1], 1'b0);

    // R6 R8: window Y edges around the current line
    for (int k = 0; k < 9; k++) begin
      if (wys[k] > 0) run_line(wys[k] - 1, 13, 250, 30, wys[k], 1'b0, 1'b1, 1'b1, 1'b0);
      run_line(wys[k] % 256, 200, 60, 7, wys[k], 1'b1, 1'b0, 1'b0, 1'b0);
      run_line((wys[k] + 9) % 256, 99, 1, 166, wys[k], 1'b0, 1'b1, 1'b0, 1'b0);
      run_line(143, 250, 255, 0, wys[k], 1'b1, 1'b1, 1'b1, 1'b0);
    end

    // R11: config changes after acceptance are ignored
    for (int k = 0; k < 8; k++)
      run_line(20 + k * 15, k * 33, k * 41, 50 + k * 9, k * 6, k[0], k[1], k[2], 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule